// File: doc/BRIEF.md
# Starvation-aware read request picker

This block sits in a memory scheduler whose read requests drain at uneven rates across storage regions. Each cycle it proposes one queued read request for issue. Requests that have waited much longer than reads normally take are promoted above everything else, so a slow region cannot be starved indefinitely. When no request is starved, the usual order applies: a request that hits the open row goes first, and among equals the older request goes first.

The block keeps its own arrival stamp for every queue slot, stamped from a free-running cycle counter when the slot is allocated. It also tracks a running average of completed read latency, which adapts to the current drain rate. Each proposal goes to an external admission check, seen here as `grant_i`. A denied slot is masked, and the block proposes the next-best slot in the following cycle. After a bounded number of consecutive denials, the mask is cleared and the full ordering applies again.

Top module: `starve_picker`

## Requirements
- R1: While `rst_ni` is low and after reset, `pick_valid_o` is 0, the average latency is `INIT_LAT`, every arrival stamp is 0, the denial mask is empty and the denial count is 0.
- R2: A pulse on `alloc_i[i]` records the current cycle count as slot i's arrival. From the next cycle on, the age of slot i is the number of clock edges since that pulse, modulo 2^`TS_W`. `entry_valid_i[i]` may rise no earlier than the cycle after the pulse.
- R3: A latency sample is taken in each cycle with `lat_valid_i` high. The scaled accumulator A, reset to 8*`INIT_LAT`, becomes A - floor(A/8) + sample. The average is floor(A/8). The starvation threshold is avg + floor(avg/8) + floor(avg/16), and a slot is starved when its age is strictly greater than the threshold.
- R4: If any candidate is starved, the pick is a starved candidate. Among starved candidates the oldest wins, and ties go to the lowest index.
- R5: If no candidate is starved and some candidate has `entry_rowhit_i` set, the pick is the oldest row-hit candidate, with ties going to the lowest index.
- R6: If no candidate is starved or a row hit, the pick is the oldest candidate, with ties going to the lowest index.
- R7: A candidate is a slot with `entry_valid_i` set that is not masked. When a pick is denied (`grant_i` low), the picked slot is masked and the denial count increases, unless this is the `MAX_RETRY`-th consecutive denial. In that case the mask and the count are cleared. A grant also clears the mask and the count.
- R8: The pick depends combinationally on the current inputs and state. `grant_i` refers to the pick shown in the same cycle. If there is no candidate, `pick_valid_o` is 0, `pick_idx_o` is 0, and the mask and count are cleared.
- R9: A slot whose `entry_valid_i` is low has its mask bit cleared at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| entry_valid_i | input | NUM_ENTRIES | Slot holds a pending read |
| entry_rowhit_i | input | NUM_ENTRIES | Slot targets the currently open row |
| alloc_i | input | NUM_ENTRIES | Pulse: slot allocated this cycle, stamp its arrival |
| lat_valid_i | input | 1 | A read completed this cycle |
| lat_sample_i | input | LAT_W | Latency of the completed read in cycles |
| grant_i | input | 1 | Admission check accepts the current pick |
| pick_valid_o | output | 1 | A candidate is proposed |
| pick_idx_o | output | $clog2(NUM_ENTRIES) | Index of the proposed slot |

## Verification
The bench uses four slots, `MAX_RETRY` of 2 and `INIT_LAT` of 24, so the initial starvation threshold is 28 cycles. With denials about half the time and latency samples between 8 and 40, slots age past the threshold within a few dozen cycles. This exercises starved ordering, row-hit ordering and plain age ordering side by side. Two denials in a row are enough to trigger the mask reset, so the bound in the denial rule comes up often. Equal-age ties arise whenever slots are allocated in the same cycle.

// File: rtl/starve_picker_pkg.sv
package starve_picker_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN   = 2'd0,
    CLS_ROWHIT  = 2'd1,
    CLS_STARVED = 2'd2
  } prio_cls_e;
endpackage

// File: rtl/lat_tracker.sv
module lat_tracker #(
  parameter int LAT_W    = 12,
  parameter int INIT_LAT = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_valid_i,
  input  logic [LAT_W-1:0] sample_i,
  output logic [LAT_W:0]   thresh_o
);
  localparam int ACC_W = LAT_W + 3;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [LAT_W-1:0] avg;

  assign acc_d = acc_q - (acc_q >> 3) + ACC_W'(sample_i);
  assign avg   = acc_q[ACC_W-1:3];
  // about 1.19 x avg
  assign thresh_o = {1'b0, avg} + (LAT_W+1)'(avg >> 3) + (LAT_W+1)'(avg >> 4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             acc_q <= ACC_W'(INIT_LAT) << 3;
    else if (sample_valid_i) acc_q <= acc_d;
  end
endmodule

// File: rtl/age_tracker.sv
module age_tracker #(
  parameter int N     = 8,
  parameter int TS_W  = 16,
  parameter int THR_W = 13
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N-1:0]             alloc_i,
  input  logic [THR_W-1:0]         thresh_i,
  output logic [N-1:0][TS_W-1:0]   age_o,
  output logic [N-1:0]             starved_o
);
  localparam int CW = (TS_W > THR_W) ? TS_W : THR_W;

  logic [TS_W-1:0]         now_q;
  logic [N-1:0][TS_W-1:0]  stamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= '0;
    else         now_q <= now_q + 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         stamp_q[i] <= '0;
      else if (alloc_i[i]) stamp_q[i] <= now_q;
    end
    assign age_o[i]     = now_q - stamp_q[i];
    assign starved_o[i] = CW'(age_o[i]) > CW'(thresh_i);
  end
endmodule

// File: rtl/pick_arb.sv
module pick_arb
  import starve_picker_pkg::*;
#(
  parameter int N    = 8,
  parameter int TS_W = 16,
  localparam int IW  = $clog2(N)
) (
  input  logic [N-1:0]           cand_i,
  input  logic [N-1:0]           starved_i,
  input  logic [N-1:0]           rowhit_i,
  input  logic [N-1:0][TS_W-1:0] age_i,
  output logic                   valid_o,
  output logic [IW-1:0]          idx_o
);
  prio_cls_e       cls     [N];
  prio_cls_e       best_cls;
  logic [TS_W-1:0] best_age;

  for (genvar i = 0; i < N; i++) begin : g_cls
    assign cls[i] = starved_i[i] ? CLS_STARVED :
                    rowhit_i[i]  ? CLS_ROWHIT  : CLS_PLAIN;
  end

  // linear scan, strict improvement keeps lowest index on ties
  always_comb begin
    valid_o  = 1'b0;
    idx_o    = '0;
    best_cls = CLS_PLAIN;
    best_age = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] &&
          (!valid_o || cls[i] > best_cls ||
           (cls[i] == best_cls && age_i[i] > best_age))) begin
        valid_o  = 1'b1;
        idx_o    = IW'(i);
        best_cls = cls[i];
        best_age = age_i[i];
      end
    end
  end
endmodule

// File: rtl/starve_picker.sv
module starve_picker #(
  parameter int NUM_ENTRIES = 8,
  parameter int TS_W        = 16,
  parameter int LAT_W       = 12,
  parameter int INIT_LAT    = 64,
  parameter int MAX_RETRY   = 3,
  localparam int IW         = $clog2(NUM_ENTRIES),
  localparam int RW         = $clog2(MAX_RETRY + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_ENTRIES-1:0] entry_valid_i,
  input  logic [NUM_ENTRIES-1:0] entry_rowhit_i,
  input  logic [NUM_ENTRIES-1:0] alloc_i,
  input  logic                   lat_valid_i,
  input  logic [LAT_W-1:0]       lat_sample_i,
  input  logic                   grant_i,
  output logic                   pick_valid_o,
  output logic [IW-1:0]          pick_idx_o
);
  localparam int THR_W = LAT_W + 1;

  logic [THR_W-1:0]                  thresh;
  logic [NUM_ENTRIES-1:0][TS_W-1:0]  age;
  logic [NUM_ENTRIES-1:0]            starved;
  logic [NUM_ENTRIES-1:0]            mask_q, mask_d, cand;
  logic [RW-1:0]                     deny_cnt_q, deny_cnt_d;

  lat_tracker #(.LAT_W(LAT_W), .INIT_LAT(INIT_LAT)) u_lat (
    .clk_i, .rst_ni,
    .sample_valid_i (lat_valid_i),
    .sample_i       (lat_sample_i),
    .thresh_o       (thresh)
  );

  age_tracker #(.N(NUM_ENTRIES), .TS_W(TS_W), .THR_W(THR_W)) u_age (
    .clk_i, .rst_ni,
    .alloc_i   (alloc_i),
    .thresh_i  (thresh),
    .age_o     (age),
    .starved_o (starved)
  );

  assign cand = entry_valid_i & ~mask_q;

  pick_arb #(.N(NUM_ENTRIES), .TS_W(TS_W)) u_arb (
    .cand_i    (cand),
    .starved_i (starved),
    .rowhit_i  (entry_rowhit_i),
    .age_i     (age),
    .valid_o   (pick_valid_o),
    .idx_o     (pick_idx_o)
  );

  always_comb begin
    mask_d     = mask_q;
    deny_cnt_d = deny_cnt_q;
    if (!pick_valid_o || grant_i || deny_cnt_q == RW'(MAX_RETRY - 1)) begin
      mask_d     = '0;
      deny_cnt_d = '0;
    end else begin
      mask_d[pick_idx_o] = 1'b1;
      deny_cnt_d         = deny_cnt_q + 1'b1;
    end
    mask_d = mask_d & entry_valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q     <= '0;
      deny_cnt_q <= '0;
    end else begin
      mask_q     <= mask_d;
      deny_cnt_q <= deny_cnt_d;
    end
  end
endmodule

// File: rtl/starve_picker_chk.sv
module starve_picker_chk #(
  parameter int N         = 8,
  parameter int MAX_RETRY = 3,
  localparam int IW       = $clog2(N),
  localparam int RW       = $clog2(MAX_RETRY + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  entry_valid_i,
  input logic [N-1:0]  entry_rowhit_i,
  input logic [N-1:0]  cand,
  input logic [N-1:0]  starved,
  input logic [N-1:0]  mask_q,
  input logic          grant_i,
  input logic          pick_valid_o,
  input logic [IW-1:0] pick_idx_o,
  input logic [RW-1:0] deny_cnt_q
);
  // R8
  idle_idx_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pick_valid_o |-> pick_idx_o == '0);

  // R7
  pick_is_candidate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_valid_o |-> entry_valid_i[pick_idx_o] && !mask_q[pick_idx_o]);

  // R4
  starved_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pick_valid_o && |(cand & starved)) |-> starved[pick_idx_o]);

  // R5
  rowhit_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pick_valid_o && !(|(cand & starved)) && |(cand & entry_rowhit_i))
      |-> entry_rowhit_i[pick_idx_o]);

  // R7
  grant_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pick_valid_o && grant_i) |=> (deny_cnt_q == '0 && mask_q == '0));

  // R7
  retry_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_cnt_q < RW'(MAX_RETRY));

  // R9
  mask_follows_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !entry_valid_i[0] |=> !mask_q[0]);
endmodule

bind starve_picker starve_picker_chk #(.N(NUM_ENTRIES), .MAX_RETRY(MAX_RETRY)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .entry_valid_i  (entry_valid_i),
  .entry_rowhit_i (entry_rowhit_i),
  .cand           (cand),
  .starved        (starved),
  .mask_q         (mask_q),
  .grant_i        (grant_i),
  .pick_valid_o   (pick_valid_o),
  .pick_idx_o     (pick_idx_o),
  .deny_cnt_q     (deny_cnt_q)
);

// File: tb/starve_picker_test.sv
module starve_picker_test;
  localparam int N    = 4;
  localparam int TS_W = 16;
  localparam int LW   = 12;
  localparam int INIT = 24;
  localparam int MR   = 2;
  localparam int IW   = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  valid = '0, rowhit = '0, alloc = '0;
  logic          lat_v = 1'b0;
  logic [LW-1:0] lat_s = '0;
  logic          grant = 1'b0;
  logic          pv;
  logic [IW-1:0] pidx;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // reference state
  int now_m, acc_m, retry_m;
  int stamp_m [N];
  bit mask_m  [N];
  bit occ     [N];
  bit pend    [N];

  starve_picker #(.NUM_ENTRIES(N), .TS_W(TS_W), .LAT_W(LW),
                  .INIT_LAT(INIT), .MAX_RETRY(MR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .entry_valid_i(valid), .entry_rowhit_i(rowhit),
    .alloc_i(alloc), .lat_valid_i(lat_v), .lat_sample_i(lat_s), .grant_i(grant),
    .pick_valid_o(pv), .pick_idx_o(pidx));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp_v, cyc);
    end
  endtask

  task automatic model_reset();
    now_m = 0; acc_m = INIT * 8; retry_m = 0;
    for (int i = 0; i < N; i++) begin
      stamp_m[i] = 0; mask_m[i] = 0; occ[i] = 0; pend[i] = 0;
    end
  endtask

  // expected pick from the requirement text; reason: 0 none, 2 starved, 1 rowhit, 3 age
  task automatic expect_pick(output bit ev, output int ei, output int why);
    int avg, thr, bc, ba;
    avg = acc_m / 8;
    thr = avg + avg / 8 + avg / 16;
    ev = 0; ei = 0; why = 0; bc = -1; ba = -1;
    for (int i = 0; i < N; i++) begin
      if (valid[i] && !mask_m[i]) begin
        int age, c;
        age = (now_m - stamp_m[i]) & 16'hFFFF;
        c = (age > thr) ? 2 : (rowhit[i] ? 1 : 0);
        if (c > bc || (c == bc && age > ba)) begin
          bc = c; ba = age; ei = i; ev = 1;
        end
      end
    end
    why = !ev ? 0 : (bc == 2 ? 2 : (bc == 1 ? 1 : 3));
  endtask

  task automatic model_step(input bit ev, input int ei);
    for (int i = 0; i < N; i++) if (alloc[i]) stamp_m[i] = now_m;
    now_m = (now_m + 1) & 16'hFFFF;
    if (lat_v) acc_m = acc_m - acc_m / 8 + lat_s;
    if (!ev || grant || retry_m == MR - 1) begin
      for (int i = 0; i < N; i++) mask_m[i] = 0;
      retry_m = 0;
    end else begin
      mask_m[ei] = 1;
      retry_m++;
    end
    for (int i = 0; i < N; i++) if (!valid[i]) mask_m[i] = 0;
    // queue bookkeeping of the bench's own stimulus
    for (int i = 0; i < N; i++) begin
      if (ev && grant && ei == i) occ[i] = 0;
      if (pend[i]) begin occ[i] = 1; pend[i] = 0; end
      if (alloc[i]) pend[i] = 1;
    end
  endtask

  // one cycle: inputs are set by the caller at negedge
  task automatic run_cycle();
    bit ev; int ei, why;
    #2;
    expect_pick(ev, ei, why);
    case (why)
      0: check(pv == 0 && pidx == 0, "R8 no candidate", {pv, pidx}, 0);
      1: check(pv && pidx == ei, "R5 row hit order", pidx, ei);
      2: check(pv && pidx == ei, "R4 starved first", pidx, ei);
      default: check(pv && pidx == ei, "R6 oldest first", pidx, ei);
    endcase
    @(posedge clk);
    model_step(ev, ei);
    @(negedge clk);
  endtask

  task automatic drive_random(input int grant_pct, input int alloc_pct);
    for (int i = 0; i < N; i++) begin
      valid[i]  = occ[i];
      rowhit[i] = ($urandom % 3) == 0;
      alloc[i]  = !occ[i] && !pend[i] && (($urandom % 100) < alloc_pct);
    end
    lat_v = ($urandom % 4) == 0;
    lat_s = LW'(8 + $urandom % 33);
    grant = ($urandom % 100) < grant_pct;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: held in reset
    check(pv == 0, "R1 reset pick_valid", pv, 0);
    rst_n = 1'b1;
    #2;
    check(pv == 0 && pidx == 0, "R1 after reset", {pv, pidx}, 0);
    @(negedge clk);

    // R2 R6: allocate slots 2 and 1 together, slot 3 later; equal ages tie to lowest index
    alloc = 4'b0110; run_cycle();
    alloc = '0; valid = 4'b0110; run_cycle();
    alloc = 4'b1000; run_cycle();
    alloc = '0; valid = 4'b1110;
    grant = 1'b0;
    // R7: repeated denials with MAX_RETRY of 2 walk and then reset the mask
    repeat (6) run_cycle();
    // R5: make slot 3 a row hit
    rowhit = 4'b1000; run_cycle();
    rowhit = '0;
    // R3 R4: wait until slots exceed threshold 28 without samples
    repeat (30) run_cycle();
    // R9: drop slot 1 while others wait
    valid = 4'b1100; repeat (3) run_cycle();
    grant = 1'b1; run_cycle();
    valid = '0; grant = 1'b0; run_cycle();
    for (int i = 0; i < N; i++) occ[i] = 0;

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      drive_random(45, 30);
      run_cycle();
    end
    // heavy denial phase to stress retry bound and starvation
    for (int k = 0; k < 2000; k++) begin
      drive_random(15, 50);
      run_cycle();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule